// File: doc/BRIEF.md
# Counting-Window Frequency Multiplier Controller

This block steers a digitally tuned oscillator so that it runs at N times a slow reference clock. It uses no phase detector and no feedback divider. It counts oscillator edges over a measurement window of reference periods. The window doubles at each sampling step, and the block judges the frequency by arithmetic on that count. The count is split into two parts. The quotient (count shifted right by the step index k) is compared with N. The remainder (the low k bits) measures how far the oscillator overshoots, and it must not exceed a programmable jitter threshold.

The reference domain measures time, and the oscillator domain counts edges. The oscillator counter runs only while a gate level from the reference side is high, and it is cleared by a separate clear level. Both levels cross through two-flop synchronisers and are echoed back the same way, so the reference side knows when the count is frozen and safe to read. Any failed comparison moves the control word and restarts the window from its first step. During acquisition the step size halves after every update, as in a binary search. After that, fine updates move the word by one.

The reference-side state machine has these states:
- `ST_IDLE` is entered when enable is low.
- `ST_CLEAR` raises the clear level and waits for its echo.
- `ST_ARM` drops the clear level and waits for the echo to fall.
- `ST_RUN` holds the gate high for the rest of the 2^k-cycle window.
- `ST_FREEZE` drops the gate and waits until the gate echo has been seen high.
- `ST_DRAIN` waits for the gate echo to fall.
- `ST_DECIDE` evaluates the count.

From `ST_DECIDE`, a pass below the last step goes to `ST_RUN` with k+1. A pass at the last step goes to `ST_CLEAR`, which is the automatic wrap. A failure updates the word and goes to `ST_CLEAR`. Disable forces `ST_IDLE`, and a change of N forces `ST_CLEAR` (or `ST_IDLE` when disabled). The word update uses a phase flag with two values: `PH_ACQ` (halving steps) and `PH_FINE` (unit steps).

Top module: `fcl_ctrl`

## Requirements
- R1: While reset is asserted, ctrl_word equals 2^(CW_W-1) (512 by default) and locked is 0.
- R2: Sampling step k (1 to MAXK) lasts 2^k reference cycles counted from the start of the window. It passes when count>>k equals N and the low k bits of the count are no larger than jit_thr. A pass advances to step k+1 without changing ctrl_word or clearing either counter.
- R3: When the quotient is below N, ctrl_word rises. When the quotient is above N, or equal to N with the remainder above jit_thr, ctrl_word falls. After either change the window restarts from step 1 with both counters cleared. A higher ctrl_word means a faster oscillator.
- R4: After a restart caused by reset or by a change of N, the first update step is 2^(CW_W-2) (256). Each following update uses half the previous step until a step of 1 has been used, and from then on every update is 1.
- R5: ctrl_word saturates at all-ones and at all-zeros and never wraps between them.
- R6: locked rises after the final step MAXK has passed twice in a row with no update in between. While it is high, the oscillator frequency lies within the counting resolution of N times the reference frequency.
- R7: When mult_n differs from its value on the previous reference edge, the next edge clears locked, returns ctrl_word to 2^(CW_W-1) and restarts acquisition.
- R8: While enable is low, ctrl_word holds its value and locked is 0. After enable returns, measurement restarts from step 1 with the held word.
- R9: The oscillator-domain counter advances only while the synchronised gate is high, holds at all-ones instead of wrapping, and is read only after the gate echo has fallen. Its width is log2(Nmax)+MAXK+1 bits, and N is zero-extended to that width for the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; the whole control path runs on it |
| osc_clk | input | 1 | Output of the controlled oscillator |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| enable | input | 1 | Runs the loop when high; holds the word when low |
| mult_n | input | NW | Multiplication factor N |
| jit_thr | input | THR_W | Largest remainder accepted as a match |
| ctrl_word | output | CW_W | Oscillator control word |
| locked | output | 1 | Frequency lock indication |

## Verification
A wrong window length or a bad quotient/remainder split shows up as a lock at the wrong frequency, or as no lock at all. This is visible at ctrl_word within a few hundred reference cycles of settling. A broken gain schedule appears in the first few changes of ctrl_word after a restart, because their sizes and signs are fixed by the oscillator's starting frequency relative to N. Saturation faults appear as ctrl_word jumping across its range when the target is out of reach. Faults in lock bookkeeping, in the handling of a change of N, or in disable handling appear at locked and ctrl_word within one reference cycle.

// File: rtl/fcl_pkg.sv
`timescale 1ps/1fs
package fcl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ARM,
        ST_RUN,
        ST_FREEZE,
        ST_DRAIN,
        ST_DECIDE
    } fcl_state_e;

    typedef enum logic {
        PH_ACQ,
        PH_FINE
    } fcl_phase_e;

endpackage

// File: rtl/fcl_sync2.sv
`timescale 1ps/1fs
module fcl_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        logic meta_q;
        logic sync_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d[gi];
                sync_q <= meta_q;
            end
        end

        assign q[gi] = sync_q;
    end

endmodule

// File: rtl/fcl_osc_count.sv
`timescale 1ps/1fs
module fcl_osc_count #(
    parameter int CNT_W = 11
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             gate_req,
    input  logic             clr_req,
    output logic [CNT_W-1:0] count,
    output logic             gate_seen,
    output logic             clr_seen
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [1:0]       req_s;
    logic             gate_s;
    logic             clr_s;
    logic [CNT_W-1:0] cnt_q;

    fcl_sync2 #(.W(2)) u_req_sync (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .d     ({gate_req, clr_req}),
        .q     (req_s)
    );

    assign gate_s = req_s[1];
    assign clr_s  = req_s[0];

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_s) begin
            cnt_q <= '0;
        end else if (gate_s && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign count     = cnt_q;
    assign gate_seen = gate_s;
    assign clr_seen  = clr_s;

    AST_FROZEN_WHILE_SHUT: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!gate_s && !clr_s) |=> $stable(cnt_q)); // R9

    AST_COUNT_HOLDS_TOP: assert property (@(posedge osc_clk) disable iff (!rst_n)
        ((cnt_q == CNT_MAX) && !clr_s) |=> (cnt_q == CNT_MAX)); // R9

endmodule

// File: rtl/fcl_decide.sv
`timescale 1ps/1fs
module fcl_decide #(
    parameter int CNT_W = 11,
    parameter int NW    = 6,
    parameter int KW    = 3,
    parameter int THR_W = 3
) (
    input  logic [CNT_W-1:0] count,
    input  logic [KW-1:0]    k,
    input  logic [NW-1:0]    n,
    input  logic [THR_W-1:0] thr,
    output logic             pass,
    output logic             raise,
    output logic             lower
);

    logic [CNT_W-1:0] quo;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] n_ext;
    logic [CNT_W-1:0] thr_ext;

    always_comb begin
        n_ext   = {{(CNT_W-NW){1'b0}}, n};
        thr_ext = {{(CNT_W-THR_W){1'b0}}, thr};
        quo     = count >> k;
        mask    = (CNT_W'(1) << k) - CNT_W'(1);
        rem     = count & mask;
        pass    = (quo == n_ext) && (rem <= thr_ext);
        raise   = (quo < n_ext);
        lower   = !pass && !raise;
    end

endmodule

// File: rtl/fcl_ctrl.sv
`timescale 1ps/1fs
module fcl_ctrl
    import fcl_pkg::*;
#(
    parameter int NW    = 6,
    parameter int MAXK  = 4,
    parameter int CW_W  = 10,
    parameter int THR_W = 3
) (
    input  logic             ref_clk,
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [NW-1:0]    mult_n,
    input  logic [THR_W-1:0] jit_thr,
    output logic [CW_W-1:0]  ctrl_word,
    output logic             locked
);

    localparam int CNT_W = NW + MAXK + 1;
    localparam int KW    = $clog2(MAXK + 1);
    localparam int RC_W  = MAXK + 1;
    localparam int GS_W  = $clog2(CW_W);
    localparam logic [CW_W-1:0] CW_MID   = {1'b1, {(CW_W-1){1'b0}}};
    localparam logic [CW_W-1:0] CW_MAX   = '1;
    localparam logic [GS_W-1:0] GAIN_TOP = GS_W'(CW_W - 2);
    localparam logic [KW-1:0]   K_FIRST  = KW'(1);
    localparam logic [KW-1:0]   K_LAST   = KW'(MAXK);

    fcl_state_e       st_q, st_n;
    fcl_phase_e       phase_q;
    logic [RC_W-1:0]  ref_cnt_q;
    logic [RC_W-1:0]  win_end;
    logic [KW-1:0]    k_q;
    logic [GS_W-1:0]  gain_sh_q;
    logic [1:0]       wraps_q;
    logic [NW-1:0]    n_q;
    logic [CW_W-1:0]  cw_q;
    logic [CW_W-1:0]  step;
    logic             locked_q;
    logic             gate_q;
    logic             clr_q;
    logic             nchg;
    logic [CNT_W-1:0] osc_count;
    logic             gate_seen;
    logic             clr_seen;
    logic [1:0]       echo_s;
    logic             gate_echo;
    logic             clr_echo;
    logic             pass;
    logic             raise;
    logic             lower;

    function automatic logic [CW_W-1:0] move_word(
        input logic [CW_W-1:0] cur,
        input logic            up,
        input logic            down,
        input logic [CW_W-1:0] amt
    );
        logic [CW_W:0] sum;
        begin
            sum = {1'b0, cur} + {1'b0, amt};
            if (up) begin
                move_word = (sum > {1'b0, CW_MAX}) ? CW_MAX : sum[CW_W-1:0];
            end else if (down) begin
                move_word = (amt > cur) ? '0 : (cur - amt);
            end else begin
                move_word = cur;
            end
        end
    endfunction

    // oscillator-domain edge counter with gate and clear levels
    fcl_osc_count #(.CNT_W(CNT_W)) u_osc_count (
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .gate_req  (gate_q),
        .clr_req   (clr_q),
        .count     (osc_count),
        .gate_seen (gate_seen),
        .clr_seen  (clr_seen)
    );

    // echoes back into the reference domain
    fcl_sync2 #(.W(2)) u_echo_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     ({gate_seen, clr_seen}),
        .q     (echo_s)
    );

    assign gate_echo = echo_s[1];
    assign clr_echo  = echo_s[0];

    fcl_decide #(
        .CNT_W (CNT_W),
        .NW    (NW),
        .KW    (KW),
        .THR_W (THR_W)
    ) u_decide (
        .count (osc_count),
        .k     (k_q),
        .n     (n_q),
        .thr   (jit_thr),
        .pass  (pass),
        .raise (raise),
        .lower (lower)
    );

    assign nchg    = (mult_n != n_q);
    assign win_end = (RC_W'(1) << k_q) - RC_W'(1);
    assign step    = CW_W'(1) << gain_sh_q;

    // next-state logic
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE:   if (enable)      st_n = ST_CLEAR;
            ST_CLEAR:  if (clr_echo)    st_n = ST_ARM;
            ST_ARM:    if (!clr_echo)   st_n = ST_RUN;
            ST_RUN:    if (ref_cnt_q == win_end) st_n = ST_FREEZE;
            ST_FREEZE: if (gate_echo)   st_n = ST_DRAIN;
            ST_DRAIN:  if (!gate_echo)  st_n = ST_DECIDE;
            ST_DECIDE: st_n = (pass && (k_q != K_LAST)) ? ST_RUN : ST_CLEAR;
            default:   st_n = ST_IDLE;
        endcase
        if (!enable) begin
            st_n = ST_IDLE;
        end else if (nchg) begin
            st_n = ST_CLEAR;
        end
    end

    // state register
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_n;
        end
    end

    // outputs and datapath
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q    <= 1'b0;
            clr_q     <= 1'b0;
            ref_cnt_q <= '0;
            k_q       <= K_FIRST;
            cw_q      <= CW_MID;
            gain_sh_q <= GAIN_TOP;
            phase_q   <= PH_ACQ;
            wraps_q   <= 2'd0;
            locked_q  <= 1'b0;
            n_q       <= '0;
        end else begin
            gate_q <= (st_n == ST_RUN);
            clr_q  <= (st_n == ST_CLEAR);
            n_q    <= mult_n;
            if (nchg) begin
                cw_q      <= CW_MID;
                gain_sh_q <= GAIN_TOP;
                phase_q   <= PH_ACQ;
                wraps_q   <= 2'd0;
                locked_q  <= 1'b0;
                k_q       <= K_FIRST;
                ref_cnt_q <= '0;
            end else if (!enable) begin
                wraps_q  <= 2'd0;
                locked_q <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_ARM: begin
                        ref_cnt_q <= '0;
                        k_q       <= K_FIRST;
                    end
                    ST_RUN: begin
                        ref_cnt_q <= ref_cnt_q + RC_W'(1);
                    end
                    ST_DECIDE: begin
                        if (pass) begin
                            if (k_q == K_LAST) begin
                                if (wraps_q == 2'd1) begin
                                    locked_q <= 1'b1;
                                end
                                if (wraps_q != 2'd2) begin
                                    wraps_q <= wraps_q + 2'd1;
                                end
                            end else begin
                                k_q <= k_q + K_FIRST;
                            end
                        end else begin
                            cw_q     <= move_word(cw_q, raise, lower, step);
                            wraps_q  <= 2'd0;
                            locked_q <= 1'b0;
                            if (phase_q == PH_ACQ) begin
                                if (gain_sh_q == '0) begin
                                    phase_q <= PH_FINE;
                                end else begin
                                    gain_sh_q <= gain_sh_q - GS_W'(1);
                                end
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign ctrl_word = cw_q;
    assign locked    = locked_q;

    AST_ONE_VERDICT: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q == ST_DECIDE) |-> $onehot({pass, raise, lower})); // R3

    AST_PASS_KEEPS_WORD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ((st_q == ST_DECIDE) && pass && enable && !nchg) |=> $stable(ctrl_word)); // R2

    AST_NO_WRAP_UP: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ((ctrl_word == CW_MAX) && !nchg) |=> (ctrl_word != '0)); // R5

    AST_NO_WRAP_DOWN: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ((ctrl_word == '0) && !nchg) |=> (ctrl_word != CW_MAX)); // R5

    AST_LOCK_ON_QUIET_WORD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(locked) |-> $stable(ctrl_word)); // R6

    AST_NEW_N_RESTARTS: assert property (@(posedge ref_clk) disable iff (!rst_n)
        nchg |=> (!locked && (ctrl_word == CW_MID))); // R7

    AST_IDLE_HOLDS_WORD: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!enable && !nchg) |=> ($stable(ctrl_word) && !locked)); // R8

    AST_READ_WHEN_SHUT: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q == ST_DECIDE) |-> (!gate_echo && !gate_q)); // R9

endmodule

// File: tb/test_fcl_ctrl.sv
`timescale 1ps/1fs
module test_fcl_ctrl;

    localparam int NW    = 6;
    localparam int MAXK  = 4;
    localparam int CW_W  = 10;
    localparam int THR_W = 3;
    localparam int MID   = 512;
    localparam int TOP   = 1023;

    logic             ref_clk = 1'b0;
    logic             osc_clk = 1'b0;
    logic             rst_n   = 1'b0;
    logic             enable  = 1'b1;
    logic [NW-1:0]    mult_n  = 6'd20;
    logic [THR_W-1:0] jit_thr = 3'd2;
    logic [CW_W-1:0]  ctrl_word;
    logic             locked;

    int nvec  = 0;
    int nfail = 0;

    fcl_ctrl #(
        .NW    (NW),
        .MAXK  (MAXK),
        .CW_W  (CW_W),
        .THR_W (THR_W)
    ) i_fcl_ctrl (
        .ref_clk   (ref_clk),
        .osc_clk   (osc_clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .mult_n    (mult_n),
        .jit_thr   (jit_thr),
        .ctrl_word (ctrl_word),
        .locked    (locked)
    );

    // 100 MHz reference
    always #5000 ref_clk = ~ref_clk;

    // oscillator model: 200 MHz + 4 MHz per control step
    always begin
        real half_ps;
        half_ps = 500000.0 / (200.0 + 4.0 * real'(int'(ctrl_word)));
        #(half_ps) osc_clk = ~osc_clk;
    end

    function automatic bit band_ok(input int n, input int thr, input int cw);
        real f, lo, hi;
        f  = 200.0 + 4.0 * real'(cw);
        lo = 100.0 * real'(n) - 12.5 - 4.0;
        hi = 100.0 * real'(n) + 100.0 * real'(thr + 2) / 16.0 + 4.0;
        return (f >= lo) && (f <= hi);
    endfunction

    function automatic int ideal_word(input int n);
        return (100 * n - 200) / 4;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge ref_clk);
    endtask

    task automatic wait_lock(input int lim, output bit ok);
        for (int c = 0; c < lim && !locked; c++) tick();
        ok = locked;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge ref_clk);
        nfail++;
        $display("FAIL R6 run timeout: actual %0d expected %0d", 190000, 0);
        finish_run();
    end

    initial begin
        int  deltas [3];
        int  got;
        int  prev;
        int  n;
        int  held;
        bit  ok;
        bit  wrapped;
        bit  seen_top;
        void'($urandom(32'd4242));

        // R1: reset state
        repeat (4) tick();
        chk(int'(ctrl_word) == MID, "R1 word in reset", int'(ctrl_word), MID);
        chk(locked == 1'b0, "R1 lock in reset", int'(locked), 0);

        // R3 / R4: binary search from mid toward a high target
        mult_n = 6'd40;
        rst_n  = 1'b1;
        prev   = int'(ctrl_word);
        got    = 0;
        for (int c = 0; c < 4000 && got < 3; c++) begin
            tick();
            if (int'(ctrl_word) != prev) begin
                deltas[got] = int'(ctrl_word) - prev;
                got++;
                prev = int'(ctrl_word);
            end
        end
        chk(got == 3, "R4 update count", got, 3);
        chk(deltas[0] == 256, "R3 R4 first step up", deltas[0], 256);
        chk(deltas[1] == 128 || deltas[1] == -128, "R4 second step", deltas[1], 128);
        chk(deltas[2] == 64 || deltas[2] == -64, "R4 third step", deltas[2], 64);
        wait_lock(20000, ok);
        chk(ok, "R6 lock after search", int'(locked), 1);
        chk(band_ok(40, 2, int'(ctrl_word)), "R2 R9 locked word band", int'(ctrl_word), ideal_word(40));

        // R7 / R2 / R6: random targets and thresholds
        for (int i = 0; i < 6; i++) begin
            do n = int'($urandom_range(4, 40)); while (n == int'(mult_n));
            mult_n  = NW'(n);
            jit_thr = THR_W'($urandom_range(2, 3));
            tick();
            chk(locked == 1'b0, "R7 lock cleared on new N", int'(locked), 0);
            chk(int'(ctrl_word) == MID, "R7 word back to mid", int'(ctrl_word), MID);
            wait_lock(20000, ok);
            chk(ok, "R6 lock for random N", n, 1);
            chk(band_ok(n, int'(jit_thr), int'(ctrl_word)), "R2 locked word band",
                int'(ctrl_word), ideal_word(n));
        end

        // R8: disable holds the word and drops lock
        held   = int'(ctrl_word);
        enable = 1'b0;
        tick();
        chk(locked == 1'b0, "R8 lock dropped when disabled", int'(locked), 0);
        repeat (300) tick();
        chk(int'(ctrl_word) == held, "R8 word held while disabled", int'(ctrl_word), held);
        chk(locked == 1'b0, "R8 lock stays low", int'(locked), 0);
        enable = 1'b1;
        wait_lock(20000, ok);
        chk(ok, "R8 relock after enable", int'(locked), 1);
        chk(band_ok(int'(mult_n), int'(jit_thr), int'(ctrl_word)), "R8 relocked band",
            int'(ctrl_word), ideal_word(int'(mult_n)));

        // R5: unreachable high target saturates at all-ones
        mult_n   = 6'd63;
        jit_thr  = 3'd2;
        wrapped  = 1'b0;
        seen_top = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            tick();
            if (int'(ctrl_word) == TOP) seen_top = 1'b1;
            if (seen_top && int'(ctrl_word) < MID) wrapped = 1'b1;
        end
        chk(int'(ctrl_word) == TOP, "R5 saturate high", int'(ctrl_word), TOP);
        chk(!wrapped, "R5 no wrap from top", int'(wrapped), 0);
        chk(locked == 1'b0, "R5 no lock out of range", int'(locked), 0);

        // R5: unreachable low target saturates at zero
        mult_n = 6'd1;
        for (int c = 0; c < 3000; c++) begin
            tick();
            if (int'(ctrl_word) == TOP) wrapped = 1'b1;
        end
        chk(int'(ctrl_word) == 0, "R5 saturate low", int'(ctrl_word), 0);
        chk(!wrapped, "R5 no wrap from zero", int'(wrapped), 0);

        finish_run();
    end

endmodule